// File: doc/BRIEF.md
# Receive Descriptor DMA Controller

This block moves packets arriving on a byte-wide serial-link stream into system memory. Software prepares a table of two-word receive descriptors. Each descriptor holds a control/status word and a buffer address. Software then enables the receiver and marks descriptors as available. When a packet starts to arrive, the controller fetches the current descriptor through a simple request/acknowledge memory port. If that descriptor is enabled, the controller copies the payload bytes into the buffer it points to. At the end marker it writes back the descriptor's control/status word with the received length and the completion flags.

If no usable descriptor exists, the packet is either thrown away or held back on the stream, depending on a no-spill setting. A memory error while a packet is being handled causes the rest of that packet to be discarded. The receiver then shuts itself off and reports the fault.

Top module: `rx_desc_dma`

## Requirements
- R1: Descriptor layout. Word 0 sits at table_base+offset: bit 31 enable, bit 30 wrap, bit 29 interrupt-enable, bit 28 truncated, bit 27 error-end, bits 15:0 buffer size on fetch and byte count on write-back. Word 1 at +4 holds the buffer address. Payload byte i of an enabled descriptor is written to buffer+i as a single-byte write.
- R2: A fetched descriptor whose bit 31 is 0 clears desc_avail. The packet is then discarded when nospill=0, or held with in_ready=0 when nospill=1.
- R3: desc_avail_set sets desc_avail and has priority over clearing. desc_avail_clr clears it without disturbing a packet in progress. While desc_avail=0, no descriptor is fetched.
- R4: rx_en_clr stops new packets, which are held with in_ready=0. A packet already in progress still completes normally. rx_en_set re-arms the receiver.
- R5: At completion, word 0 is written back with bits 31, 30 and 29 cleared and bits 15:0 set to the number of bytes stored. Bit 27 is set when the packet ended with an error-end marker (in_eep).
- R6: Bytes beyond the buffer size are discarded up to the end marker. Bit 28 is then set in the written-back word, and the length equals the buffer size.
- R7: After a write-back, the descriptor offset advances by 8, or returns to 0 when the descriptor's wrap bit was set.
- R8: Every completed packet sets pkt_rcvd. irq is also set when the descriptor's bit 29 was set. status_clr bit 0 clears pkt_rcvd, bit 1 clears irq and bit 2 clears bus_err (write-one-to-clear). A set event wins over a clear.
- R9: An error response on the memory port discards the remaining input up to and including the next end marker. After that, rx_enabled drops and bus_err rises, and no descriptor write-back is made.
- R10: mem_req, mem_addr and mem_we stay stable until mem_ack. Descriptor reads are word-aligned, and every write carries a non-zero strobe.
- R11: After reset, all status outputs, mem_req and in_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | AW | Base address of the descriptor table (8-byte aligned) |
| rx_en_set | input | 1 | Pulse: enable the receiver |
| rx_en_clr | input | 1 | Pulse: disable the receiver |
| desc_avail_set | input | 1 | Pulse: descriptors available |
| desc_avail_clr | input | 1 | Pulse: withdraw descriptor availability |
| nospill | input | 1 | 1 holds packets that lack a descriptor, 0 discards them |
| status_clr | input | 3 | Write-one-to-clear for pkt_rcvd, irq, bus_err |
| in_valid | input | 1 | Input symbol valid |
| in_data | input | 8 | Payload byte |
| in_eop | input | 1 | Symbol is a normal end marker |
| in_eep | input | 1 | Symbol is an error-end marker |
| in_ready | output | 1 | Symbol accepted on this edge when valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rx_enabled | output | 1 | Receiver enable state |
| desc_avail | output | 1 | Descriptor-available flag |
| pkt_rcvd | output | 1 | Packet-received status |
| irq | output | 1 | Interrupt flag |
| bus_err | output | 1 | Memory error status |

## Verification
A wrong descriptor offset becomes visible on the next packet. That packet lands in the wrong buffer, or its write-back hits the wrong table slot, and both show up in memory a few cycles after the end marker. A stuck state in the receive sequencer shows up immediately as in_ready wrongly low, so packets are held, or wrongly high, so bytes are swallowed without a write. A wrong byte counter shows up in the written-back length and in buffer bytes that are missing or misplaced. Corrupted flag state shows up on the status outputs within one cycle of the event that should have changed it.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int EN_BIT = 31;
  localparam int WR_BIT = 30;
  localparam int IE_BIT = 29;
  localparam int TR_BIT = 28;
  localparam int EE_BIT = 27;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RECV, ST_WRB, ST_WB, ST_SPILL, ST_ESPILL
  } rdma_state_e;
endpackage

// File: rtl/rdma_flags.sv
module rdma_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en_set,
  input  logic       rx_en_clr,
  input  logic       avail_set,
  input  logic       avail_clr,
  input  logic [2:0] status_clr,
  input  logic       hw_avail_clr,
  input  logic       hw_done,
  input  logic       hw_irq,
  input  logic       hw_bus_err,
  output logic       rx_enabled,
  output logic       desc_avail,
  output logic       pkt_rcvd,
  output logic       irq,
  output logic       bus_err
);
  logic rxen_n, avail_n, pkt_n, irq_n, berr_n;

  always_comb begin
    rxen_n = rx_enabled;
    if (rx_en_set) rxen_n = 1'b1;
    if (rx_en_clr || hw_bus_err) rxen_n = 1'b0;
    avail_n = desc_avail;
    if (avail_clr || hw_avail_clr) avail_n = 1'b0;
    if (avail_set) avail_n = 1'b1;
    pkt_n = pkt_rcvd;
    if (status_clr[0]) pkt_n = 1'b0;
    if (hw_done) pkt_n = 1'b1;
    irq_n = irq;
    if (status_clr[1]) irq_n = 1'b0;
    if (hw_irq) irq_n = 1'b1;
    berr_n = bus_err;
    if (status_clr[2]) berr_n = 1'b0;
    if (hw_bus_err) berr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_enabled <= 1'b0;
      desc_avail <= 1'b0;
      pkt_rcvd   <= 1'b0;
      irq        <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      rx_enabled <= rxen_n;
      desc_avail <= avail_n;
      pkt_rcvd   <= pkt_n;
      irq        <= irq_n;
      bus_err    <= berr_n;
    end
  end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] offset
);
  localparam logic [AW-1:0] STEP = AW'(8);
  logic [AW-1:0] off_n;

  always_comb begin
    off_n = offset;
    if (advance) off_n = wrap ? '0 : offset + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       offset <= '0;
    else if (advance) offset <= off_n;
  end
endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm import rdma_pkg::*; #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enabled,
  input  logic          desc_avail,
  input  logic          nospill,
  input  logic [AW-1:0] desc_addr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eop,
  input  logic          in_eep,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          ev_avail_clr,
  output logic          ev_done,
  output logic          ev_irq,
  output logic          ev_bus_err,
  output logic          ptr_adv,
  output logic          ptr_wrap
);
  localparam logic [AW-1:0] W1_OFS = AW'(4);

  rdma_state_e state_q, state_n;
  logic [LEN_W-1:0] len_q, len_n, cnt_q, cnt_n;
  logic [AW-1:0]    buf_q, buf_n, wr_addr;
  logic [7:0]       byte_q, byte_n;
  logic             wr_q, wr_n, ie_q, ie_n, tr_q, tr_n, ee_q, ee_n;
  logic             marker;
  logic [31:0]      wb_word;

  assign marker  = in_eop | in_eep;
  assign wr_addr = buf_q + AW'(cnt_q);

  always_comb begin
    wb_word = '0;
    wb_word[LEN_W-1:0] = cnt_q;
    wb_word[TR_BIT] = tr_q;
    wb_word[EE_BIT] = ee_q;
  end

  always_comb begin
    state_n = state_q; len_n = len_q; cnt_n = cnt_q; buf_n = buf_q;
    byte_n = byte_q; wr_n = wr_q; ie_n = ie_q; tr_n = tr_q; ee_n = ee_q;
    in_ready = 1'b0; mem_req = 1'b0; mem_we = 1'b0; mem_addr = desc_addr;
    mem_wdata = '0; mem_wstrb = '0;
    ev_avail_clr = 1'b0; ev_done = 1'b0; ev_irq = 1'b0; ev_bus_err = 1'b0;
    ptr_adv = 1'b0; ptr_wrap = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid && rx_enabled) begin
        if (desc_avail)    state_n = ST_RD0;
        else if (!nospill) state_n = ST_SPILL;
      end
      ST_RD0: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_err) state_n = ST_ESPILL;
          else if (!mem_rdata[EN_BIT]) begin
            ev_avail_clr = 1'b1;
            state_n = ST_IDLE;
          end else begin
            len_n = mem_rdata[LEN_W-1:0];
            wr_n = mem_rdata[WR_BIT];
            ie_n = mem_rdata[IE_BIT];
            cnt_n = '0; tr_n = 1'b0; ee_n = 1'b0;
            state_n = ST_RD1;
          end
        end
      end
      ST_RD1: begin
        mem_req = 1'b1;
        mem_addr = desc_addr + W1_OFS;
        if (mem_ack) begin
          if (mem_err) state_n = ST_ESPILL;
          else begin
            buf_n = mem_rdata[AW-1:0];
            state_n = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (marker) begin
            ee_n = in_eep;
            state_n = ST_WB;
          end else if (cnt_q == len_q) tr_n = 1'b1;
          else begin
            byte_n = in_data;
            state_n = ST_WRB;
          end
        end
      end
      ST_WRB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr;
        mem_wdata = {4{byte_q}};
        mem_wstrb = 4'b0001 << wr_addr[1:0];
        if (mem_ack) begin
          if (mem_err) state_n = ST_ESPILL;
          else begin
            cnt_n = cnt_q + 1'b1;
            state_n = ST_RECV;
          end
        end
      end
      ST_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word; mem_wstrb = 4'hF;
        if (mem_ack) begin
          state_n = ST_IDLE;
          if (mem_err) ev_bus_err = 1'b1;
          else begin
            ev_done = 1'b1; ev_irq = ie_q; ptr_adv = 1'b1; ptr_wrap = wr_q;
          end
        end
      end
      ST_SPILL: begin
        in_ready = 1'b1;
        if (in_valid && marker) state_n = ST_IDLE;
      end
      ST_ESPILL: begin
        in_ready = 1'b1;
        if (in_valid && marker) begin
          ev_bus_err = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; len_q <= '0; cnt_q <= '0; buf_q <= '0; byte_q <= '0;
      wr_q <= 1'b0; ie_q <= 1'b0; tr_q <= 1'b0; ee_q <= 1'b0;
    end else begin
      state_q <= state_n; len_q <= len_n; cnt_q <= cnt_n; buf_q <= buf_n;
      byte_q <= byte_n; wr_q <= wr_n; ie_q <= ie_n; tr_q <= tr_n; ee_q <= ee_n;
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] table_base,
  input  logic          rx_en_set,
  input  logic          rx_en_clr,
  input  logic          desc_avail_set,
  input  logic          desc_avail_clr,
  input  logic          nospill,
  input  logic [2:0]    status_clr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eop,
  input  logic          in_eep,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          rx_enabled,
  output logic          desc_avail,
  output logic          pkt_rcvd,
  output logic          irq,
  output logic          bus_err
);
  logic [AW-1:0] offset, desc_addr;
  logic ev_avail_clr, ev_done, ev_irq, ev_bus_err, ptr_adv, ptr_wrap;

  assign desc_addr = table_base + offset;

  rdma_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .rx_en_set(rx_en_set), .rx_en_clr(rx_en_clr),
    .avail_set(desc_avail_set), .avail_clr(desc_avail_clr),
    .status_clr(status_clr),
    .hw_avail_clr(ev_avail_clr), .hw_done(ev_done), .hw_irq(ev_irq),
    .hw_bus_err(ev_bus_err),
    .rx_enabled(rx_enabled), .desc_avail(desc_avail), .pkt_rcvd(pkt_rcvd),
    .irq(irq), .bus_err(bus_err)
  );

  rdma_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(ptr_adv), .wrap(ptr_wrap), .offset(offset)
  );

  rdma_fsm #(.AW(AW), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .rx_enabled(rx_enabled), .desc_avail(desc_avail), .nospill(nospill),
    .desc_addr(desc_addr),
    .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop), .in_eep(in_eep),
    .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .ev_avail_clr(ev_avail_clr), .ev_done(ev_done), .ev_irq(ev_irq),
    .ev_bus_err(ev_bus_err), .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap)
  );
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] table_base,
  input logic          desc_avail_set,
  input logic          desc_avail_clr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_wstrb,
  input logic          mem_ack,
  input logic          rx_enabled,
  input logic          desc_avail,
  input logic          pkt_rcvd,
  input logic          irq,
  input logic          bus_err
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wstrb != 4'h0);

  // R1
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && table_base[2:0] == 3'b000 |-> mem_addr[1:0] == 2'b00);

  // R3
  avail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_avail_clr && !desc_avail_set |=> !desc_avail);

  // R3
  avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_avail_set |=> desc_avail);

  // R8
  irq_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> pkt_rcvd);

  // R9
  err_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> !rx_enabled);
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .table_base(table_base),
  .desc_avail_set(desc_avail_set), .desc_avail_clr(desc_avail_clr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
  .rx_enabled(rx_enabled), .desc_avail(desc_avail), .pkt_rcvd(pkt_rcvd),
  .irq(irq), .bus_err(bus_err)
);

// File: tb/rx_desc_dma_bench.sv
module rx_desc_dma_bench;
  localparam int AW = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] table_base = 32'h100;
  logic rx_en_set = 0, rx_en_clr = 0, desc_avail_set = 0, desc_avail_clr = 0;
  logic nospill = 0;
  logic [2:0] status_clr = 0;
  logic in_valid = 0, in_eop = 0, in_eep = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [3:0] mem_wstrb;
  logic mem_ack = 0, mem_err = 0;
  logic rx_enabled, desc_avail, pkt_rcvd, irq, bus_err;

  int checks = 0, failures = 0;
  logic [7:0] mem8 [0:1023];
  logic err_arm = 0;
  logic [AW-1:0] err_addr = 0;

  always #4 clk = ~clk;

  rx_desc_dma u_rx_desc_dma (.*);

  // memory model: one acknowledge per access, answered on the falling edge
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; mem_err = 0;
    end else if (rst_n && mem_req) begin
      mem_ack = 1;
      if (err_arm && mem_addr == err_addr) mem_err = 1;
      else if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem8[{mem_addr[9:2], 2'(b)}] = mem_wdata[8*b +: 8];
      end else
        mem_rdata = {mem8[mem_addr[9:0]+3], mem8[mem_addr[9:0]+2],
                     mem8[mem_addr[9:0]+1], mem8[mem_addr[9:0]]};
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem8[a+3], mem8[a+2], mem8[a+1], mem8[a]};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
    for (int b = 0; b < 4; b++) begin
      mem8[a+b] = w0[8*b +: 8];
      mem8[a+4+b] = w1[8*b +: 8];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_en_set = 1; 1: rx_en_clr = 1; 2: desc_avail_set = 1; 3: desc_avail_clr = 1;
      default: ;
    endcase
    @(negedge clk);
    rx_en_set = 0; rx_en_clr = 0; desc_avail_set = 0; desc_avail_clr = 0;
  endtask

  task automatic clr_status(input logic [2:0] m);
    @(negedge clk); status_clr = m;
    @(negedge clk); status_clr = 0;
  endtask

  task automatic present(input logic [7:0] d, input logic eop, input logic eep);
    @(negedge clk);
    in_valid = 1; in_data = d; in_eop = eop; in_eep = eep;
  endtask

  task automatic send(input logic [7:0] d, input logic eop, input logic eep);
    present(d, eop, eep);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_eop = 0; in_eep = 0;
  endtask

  task automatic hold_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, in_ready, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem8[i] = 8'h00;
    // R1 table: desc0 enabled+IE len 8 buf 0x200; desc1 enabled+wrap len 4 buf 0x240
    put_desc(32'h100, 32'hA000_0008, 32'h200);
    put_desc(32'h108, 32'hC000_0004, 32'h240);
    idle(3);
    // R11 reset state
    chk("R11 mem_req", mem_req, 0);
    chk("R11 in_ready", in_ready, 0);
    chk("R11 flags", {rx_enabled, desc_avail, pkt_rcvd, irq, bus_err}, 0);
    rst_n = 1;
    idle(2);

    // A: normal packet into desc0 (R1 R5 R8)
    pulse(0); pulse(2);
    for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), 0, 0);
    send(0, 1, 0);
    idle(8);
    for (int i = 0; i < 5; i++) chk("R1 buffer byte", mem8[32'h200 + i], 8'hA0 + 8'(i));
    chk("R1 no byte beyond count", mem8[32'h205], 0);
    chk("R5 writeback word", rd32(32'h100), 32'h0000_0005);
    chk("R8 pkt_rcvd", pkt_rcvd, 1);
    chk("R8 irq with IE", irq, 1);
    clr_status(3'b011);
    chk("R8 w1c clears", {pkt_rcvd, irq}, 0);

    // B: truncation + EEP + wrap (R6 R5 R7 R8)
    for (int i = 0; i < 6; i++) send(8'hB0 + 8'(i), 0, 0);
    send(0, 0, 1);
    idle(8);
    chk("R6 stored bytes", rd32(32'h240), 32'hB3B2_B1B0);
    chk("R6 excess dropped", mem8[32'h244], 0);
    chk("R6 R5 writeback trunc+eep", rd32(32'h108), 32'h1800_0004);
    chk("R8 pkt no IE", {pkt_rcvd, irq}, 2'b10);
    clr_status(3'b001);

    // C: wrap leads back to desc0, now disabled; spill with nospill=0 (R7 R2)
    for (int i = 0; i < 3; i++) send(8'hC0 + 8'(i), 0, 0);
    send(0, 1, 0);
    idle(8);
    chk("R2 avail cleared", desc_avail, 0);
    chk("R7 R2 desc0 untouched", rd32(32'h100), 32'h0000_0005);
    chk("R2 old buffer untouched", mem8[32'h200], 8'hA0);
    chk("R2 no completion", pkt_rcvd, 0);

    // D: nospill=1, no descriptor: held (R2 R3)
    nospill = 1;
    present(8'h11, 0, 0);
    hold_check("R3 held without avail", 12);
    put_desc(32'h100, 32'h8000_0008, 32'h300);
    pulse(2);
    send(8'h11, 0, 0); send(8'h12, 0, 0); send(8'h13, 0, 0); send(0, 1, 0);
    idle(8);
    chk("R3 stored after set", rd32(32'h300), 32'h0013_1211);
    chk("R5 writeback D", rd32(32'h100), 32'h0000_0003);

    // E: clears mid-packet do not disturb it (R3 R4 R7)
    put_desc(32'h108, 32'hA000_0008, 32'h340);
    put_desc(32'h110, 32'h8000_0008, 32'h380);
    send(8'hE0, 0, 0); send(8'hE1, 0, 0);
    pulse(3); pulse(1);
    send(8'hE2, 0, 0); send(0, 1, 0);
    idle(8);
    chk("R4 R3 packet completes", rd32(32'h340), 32'h00E2_E1E0);
    chk("R7 desc1 used after desc0", rd32(32'h108), 32'h0000_0003);
    chk("R4 rx off", {rx_enabled, desc_avail}, 0);
    present(8'hF0, 0, 0);
    hold_check("R4 held while disabled", 12);
    pulse(0); pulse(2);
    send(8'hF0, 0, 0); send(8'hF1, 0, 0); send(0, 1, 0);
    idle(8);
    chk("R4 re-armed", rd32(32'h380) & 32'hFFFF, 32'hF1F0);
    chk("R7 desc2 writeback", rd32(32'h110), 32'h0000_0002);

    // F: bus error on the second buffer write (R9)
    nospill = 0;
    clr_status(3'b011);
    put_desc(32'h118, 32'h8000_0008, 32'h3C0);
    err_arm = 1; err_addr = 32'h3C1;
    for (int i = 0; i < 4; i++) send(8'hD0 + 8'(i), 0, 0);
    send(0, 1, 0);
    idle(8);
    err_arm = 0;
    chk("R9 bus_err set", bus_err, 1);
    chk("R9 rx disabled", rx_enabled, 0);
    chk("R9 first byte written", mem8[32'h3C0], 8'hD0);
    chk("R9 rest dropped", mem8[32'h3C2], 0);
    chk("R9 no writeback", rd32(32'h118), 32'h8000_0008);
    chk("R9 no completion", pkt_rcvd, 0);
    present(8'h55, 0, 0);
    hold_check("R9 idle after error", 6);
    @(negedge clk); in_valid = 0;
    clr_status(3'b100);
    chk("R8 bus_err w1c", bus_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule